// File: doc/BRIEF.md
# Floating-Point NaN Classifier and Quieter

This block is a purely combinational unit. It takes one half-, single- or double-precision value and reports three things: whether the value is a NaN, whether it is a quiet NaN, and whether it is a signaling NaN. It also provides two values. The first is a quieted copy of the input. The second is the default NaN pattern for the active mode. A single invalid flag is raised whenever the input is a signaling NaN. The parameter `FMT` fixes the storage format when the block is built.

The input `sig_msb_set_i` sets, at run time, what the most significant fraction bit means.

- When it is 0, a clear bit marks a signaling NaN. Quieting sets that bit. The default NaN has only that bit set in its fraction.
- When it is 1, a set bit marks a signaling NaN. Quieting replaces the value with the default NaN. That default NaN has every fraction bit set except the most significant one.

The static parameter `NO_SNAN` removes signaling NaNs altogether. With it set, every NaN counts as quiet.

Top module: `nan_classifier`

## Requirements
- R1: With `sig_msb_set_i`=0, a value whose exponent is all ones and whose fraction MSB is 1 is a quiet NaN. A value whose exponent is all ones, whose fraction MSB is 0 and whose remaining fraction bits are not all zero is a signaling NaN. For single precision the exponent is bits [30:23] and the fraction MSB is bit 22.
- R2: With `sig_msb_set_i`=1 the two tests swap. An all-ones exponent with fraction MSB 1 is signaling. An all-ones exponent with fraction MSB 0 and a nonzero remainder is quiet.
- R3: An infinity or any non-NaN value drives all three classification outputs to 0. `is_quiet_o` and `is_sig_o` are never both 1, and `is_nan_o` is their OR.
- R4: `invalid_o` is 1 exactly when `is_sig_o` is 1.
- R5: With `sig_msb_set_i`=0, `quieted_o` for a signaling input is the input with the fraction MSB set. For any non-signaling input, in either mode, `quieted_o` equals the input.
- R6: With `sig_msb_set_i`=1, `quieted_o` for a signaling input equals the default NaN.
- R7: The default NaN has sign 0 and an all-ones exponent. With `sig_msb_set_i`=0 only the fraction MSB is set (single precision 0x7FC00000). With `sig_msb_set_i`=1 all fraction bits except the MSB are set (single precision 0x7FBFFFFF).
- R8: With `NO_SNAN`=1, every NaN is reported quiet, `is_sig_o` and `invalid_o` stay 0, and `quieted_o` equals the input.
- R9: The format parameter selects the field positions. `FMT`=0 is half precision: exponent [14:10], fraction MSB bit 9. `FMT`=2 is double precision: exponent [62:52], fraction MSB bit 51. `FMT`=1 is single precision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| val_i | input | W (16/32/64 by FMT) | Value to classify |
| sig_msb_set_i | input | 1 | 1: set fraction MSB marks signaling; 0: clear MSB marks signaling |
| is_nan_o | output | 1 | Input is a NaN of either kind |
| is_quiet_o | output | 1 | Input is a quiet NaN |
| is_sig_o | output | 1 | Input is a signaling NaN |
| invalid_o | output | 1 | Invalid-operation flag for a signaling input |
| quieted_o | output | W | Quieted copy of the input |
| dflt_nan_o | output | W | Default NaN for the active mode |

## Verification
Every result is combinational, so it is due in the same cycle as the stimulus, with zero register stages. The bench changes inputs just after a rising clock edge and samples all outputs half a period later, at the falling edge, when the logic has long settled. The stimulus covers both modes, infinities, values with the sign bit set, all three formats, and a build with signaling NaNs disabled.

// File: rtl/nan_cls_pkg.sv
// Package: format geometry shared by the NaN classifier and its checker.
// Assumes FMT is 0 (half), 1 (single) or 2 (double); other values map to single.
package nan_cls_pkg;

    // Exponent width for a format code.
    function automatic int exp_width(input int fmt);
        case (fmt)
            0:       return 5;
            2:       return 11;
            default: return 8;
        endcase
    endfunction

    // Stored fraction width for a format code.
    function automatic int frac_width(input int fmt);
        case (fmt)
            0:       return 10;
            2:       return 52;
            default: return 23;
        endcase
    endfunction

    // Total width: sign, exponent and fraction.
    function automatic int word_width(input int fmt);
        return 1 + exp_width(fmt) + frac_width(fmt);
    endfunction

endpackage

// File: rtl/nan_field_split.sv
// Module: nan_field_split
// Extracts the facts that NaN classification needs from one encoded value:
// whether the exponent is all ones, the fraction MSB, and whether the fraction
// bits below the MSB are nonzero. Assumes FW >= 2.
module nan_field_split #(
    parameter int EW = 8,
    parameter int FW = 23,
    localparam int W = 1 + EW + FW
) (
    input  logic [W-1:0] val_i,
    output logic         exp_ones_o,
    output logic         frac_msb_o,
    output logic         frac_rest_nz_o
);

    logic [EW-1:0] exp_field;
    logic [FW-1:0] frac_field;

    // Separates the exponent and fraction fields.
    always_comb begin
        exp_field  = val_i[W-2 -: EW];
        frac_field = val_i[FW-1:0];
    end

    // Derives the three classification facts.
    always_comb begin
        exp_ones_o     = &exp_field;
        frac_msb_o     = frac_field[FW-1];
        frac_rest_nz_o = |frac_field[FW-2:0];
    end

endmodule

// File: rtl/nan_class_decode.sv
// Module: nan_class_decode
// Turns the field facts into quiet / signaling / any-NaN flags.
// The mode bit sets the meaning of the fraction MSB. The NO_SNAN parameter
// folds every NaN into the quiet class. Purely combinational.
module nan_class_decode #(
    parameter bit NO_SNAN = 1'b0
) (
    input  logic exp_ones_i,
    input  logic frac_msb_i,
    input  logic frac_rest_nz_i,
    input  logic sig_msb_set_i,
    output logic any_nan_o,
    output logic quiet_o,
    output logic sig_o
);

    logic msb_nan;
    logic rest_nan;

    // NaN with the fraction MSB set, and NaN with only lower fraction bits set.
    always_comb begin
        msb_nan  = exp_ones_i & frac_msb_i;
        rest_nan = exp_ones_i & ~frac_msb_i & frac_rest_nz_i;
    end

    generate
        if (NO_SNAN) begin : g_no_snan
            // Every NaN is quiet when signaling NaNs are disabled.
            always_comb begin
                quiet_o = msb_nan | rest_nan;
                sig_o   = 1'b0;
            end
        end else begin : g_snan
            // The mode bit picks which NaN group is signaling.
            always_comb begin
                if (sig_msb_set_i) begin
                    quiet_o = rest_nan;
                    sig_o   = msb_nan;
                end else begin
                    quiet_o = msb_nan;
                    sig_o   = rest_nan;
                end
            end
        end
    endgenerate

    // Any NaN is the union of both classes.
    always_comb any_nan_o = quiet_o | sig_o;

endmodule

// File: rtl/nan_pattern_gen.sv
// Module: nan_pattern_gen
// Builds the default NaN for the active mode and the quieted copy of the input.
// Assumes sig_i is already the signaling classification of val_i.
module nan_pattern_gen #(
    parameter int EW = 8,
    parameter int FW = 23,
    localparam int W = 1 + EW + FW
) (
    input  logic [W-1:0] val_i,
    input  logic         sig_msb_set_i,
    input  logic         sig_i,
    output logic [W-1:0] dflt_o,
    output logic [W-1:0] quieted_o
);

    localparam logic [W-1:0] MSB_MASK  = W'(1) << (FW - 1);
    localparam logic [W-1:0] EXP_ONES  = ((W'(1) << EW) - W'(1)) << FW;
    localparam logic [W-1:0] REST_ONES = MSB_MASK - W'(1);

    // Default NaN: positive sign and all-ones exponent; the fraction depends on the mode.
    always_comb begin
        dflt_o = sig_msb_set_i ? (EXP_ONES | REST_ONES) : (EXP_ONES | MSB_MASK);
    end

    // Quieting: set the MSB, or substitute the default NaN; non-signaling values pass through.
    always_comb begin
        if (!sig_i) begin
            quieted_o = val_i;
        end else if (sig_msb_set_i) begin
            quieted_o = dflt_o;
        end else begin
            quieted_o = val_i | MSB_MASK;
        end
    end

endmodule

// File: rtl/nan_classifier.sv
// Module: nan_classifier (top)
// Combinational NaN classifier and quieter for half, single or double precision.
// Assumes FMT in {0,1,2}. No clock or reset: all outputs follow the inputs.
module nan_classifier
    import nan_cls_pkg::*;
#(
    parameter int FMT     = 1,
    parameter bit NO_SNAN = 1'b0,
    localparam int EW = exp_width(FMT),
    localparam int FW = frac_width(FMT),
    localparam int W  = 1 + EW + FW
) (
    input  logic [W-1:0] val_i,
    input  logic         sig_msb_set_i,
    output logic         is_nan_o,
    output logic         is_quiet_o,
    output logic         is_sig_o,
    output logic         invalid_o,
    output logic [W-1:0] quieted_o,
    output logic [W-1:0] dflt_nan_o
);

    logic exp_ones;
    logic frac_msb;
    logic frac_rest_nz;

    nan_field_split #(.EW(EW), .FW(FW)) u_split (
        .val_i          (val_i),
        .exp_ones_o     (exp_ones),
        .frac_msb_o     (frac_msb),
        .frac_rest_nz_o (frac_rest_nz)
    );

    nan_class_decode #(.NO_SNAN(NO_SNAN)) u_decode (
        .exp_ones_i     (exp_ones),
        .frac_msb_i     (frac_msb),
        .frac_rest_nz_i (frac_rest_nz),
        .sig_msb_set_i  (sig_msb_set_i),
        .any_nan_o      (is_nan_o),
        .quiet_o        (is_quiet_o),
        .sig_o          (is_sig_o)
    );

    nan_pattern_gen #(.EW(EW), .FW(FW)) u_pattern (
        .val_i         (val_i),
        .sig_msb_set_i (sig_msb_set_i),
        .sig_i         (is_sig_o),
        .dflt_o        (dflt_nan_o),
        .quieted_o     (quieted_o)
    );

    // The invalid flag marks a signaling operand.
    always_comb invalid_o = is_sig_o;

endmodule

// File: rtl/nan_classifier_chk.sv
// Module: nan_classifier_chk
// Immediate assertions on the classifier outputs, attached by bind.
// Assumes the same FMT/NO_SNAN as the bound instance.
module nan_classifier_chk
    import nan_cls_pkg::*;
#(
    parameter int FMT     = 1,
    parameter bit NO_SNAN = 1'b0,
    localparam int EW = exp_width(FMT),
    localparam int FW = frac_width(FMT),
    localparam int W  = 1 + EW + FW
) (
    input logic [W-1:0] val_i,
    input logic         sig_msb_set_i,
    input logic         is_nan_o,
    input logic         is_quiet_o,
    input logic         is_sig_o,
    input logic         invalid_o,
    input logic [W-1:0] quieted_o,
    input logic [W-1:0] dflt_nan_o
);

    localparam logic [W-1:0] MSB_MASK = W'(1) << (FW - 1);

    logic is_inf;

    // Infinity: all-ones exponent and zero fraction.
    always_comb is_inf = (&val_i[W-2 -: EW]) && (val_i[FW-1:0] == '0);

    // Output relations checked on every input change.
    always_comb begin
        AST_CLASS_EXCLUSIVE: assert (!(is_quiet_o && is_sig_o));                       // R3
        AST_INF_NOT_NAN: assert (!is_inf || !is_nan_o);                                // R3
        AST_INVALID_IS_SIG: assert (invalid_o == is_sig_o);                             // R4
        AST_PASS_NON_SIG: assert (is_sig_o || quieted_o == val_i);                      // R5
        AST_SET_MSB: assert (!is_sig_o || sig_msb_set_i || (quieted_o ^ val_i) == MSB_MASK); // R5
        AST_SIG_TO_DFLT: assert (!is_sig_o || !sig_msb_set_i || quieted_o == dflt_nan_o); // R6
        AST_DFLT_SHAPE: assert (!dflt_nan_o[W-1] && (&dflt_nan_o[W-2 -: EW]));          // R7
        AST_NO_SNAN_QUIET: assert (!NO_SNAN || !is_sig_o);                              // R8
    end

endmodule

bind nan_classifier nan_classifier_chk #(.FMT(FMT), .NO_SNAN(NO_SNAN)) u_chk (.*);

// File: tb/tb_nan_classifier.sv
module tb_nan_classifier;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 10;

    // Vector fields: {mode, input[31:0], nan, quiet, sig, quieted[31:0]}
    localparam logic [67:0] VEC [NVEC] = '{
        {1'b0, 32'h7FC00000, 3'b110, 32'h7FC00000},
        {1'b0, 32'h7F800001, 3'b101, 32'h7FC00001},
        {1'b0, 32'hFF800000, 3'b000, 32'hFF800000},
        {1'b0, 32'hFFA00000, 3'b101, 32'hFFE00000},
        {1'b0, 32'h3F800000, 3'b000, 32'h3F800000},
        {1'b0, 32'hFFFFFFFF, 3'b110, 32'hFFFFFFFF},
        {1'b1, 32'h7FC00000, 3'b101, 32'h7FBFFFFF},
        {1'b1, 32'h7F800001, 3'b110, 32'h7F800001},
        {1'b1, 32'h7F800000, 3'b000, 32'h7F800000},
        {1'b1, 32'hFFC00001, 3'b101, 32'h7FBFFFFF}
    };

    logic clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Single-precision device under test
    logic [31:0] s_val; logic s_mode;
    logic s_nan, s_q, s_s, s_inv; logic [31:0] s_qo, s_df;
    nan_classifier #(.FMT(1)) dut (
        .val_i(s_val), .sig_msb_set_i(s_mode), .is_nan_o(s_nan), .is_quiet_o(s_q),
        .is_sig_o(s_s), .invalid_o(s_inv), .quieted_o(s_qo), .dflt_nan_o(s_df));

    // Signaling NaNs disabled
    logic [31:0] n_val; logic n_mode;
    logic n_nan, n_q, n_s, n_inv; logic [31:0] n_qo, n_df;
    nan_classifier #(.FMT(1), .NO_SNAN(1'b1)) dut_ns (
        .val_i(n_val), .sig_msb_set_i(n_mode), .is_nan_o(n_nan), .is_quiet_o(n_q),
        .is_sig_o(n_s), .invalid_o(n_inv), .quieted_o(n_qo), .dflt_nan_o(n_df));

    // Half precision
    logic [15:0] h_val; logic h_mode;
    logic h_nan, h_q, h_s, h_inv; logic [15:0] h_qo, h_df;
    nan_classifier #(.FMT(0)) dut_h (
        .val_i(h_val), .sig_msb_set_i(h_mode), .is_nan_o(h_nan), .is_quiet_o(h_q),
        .is_sig_o(h_s), .invalid_o(h_inv), .quieted_o(h_qo), .dflt_nan_o(h_df));

    // Double precision
    logic [63:0] d_val; logic d_mode;
    logic d_nan, d_q, d_s, d_inv; logic [63:0] d_qo, d_df;
    nan_classifier #(.FMT(2)) dut_d (
        .val_i(d_val), .sig_msb_set_i(d_mode), .is_nan_o(d_nan), .is_quiet_o(d_q),
        .is_sig_o(d_s), .invalid_o(d_inv), .quieted_o(d_qo), .dflt_nan_o(d_df));

    task automatic chk(input string req, input string what, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Inputs change just after a rising edge; results are combinational and sampled at the falling edge.
    task automatic settle();
        @(posedge clk);
        #1;
        @(negedge clk);
    endtask

    initial begin
        s_val = '0; s_mode = 1'b0; n_val = '0; n_mode = 1'b0;
        h_val = '0; h_mode = 1'b0; d_val = '0; d_mode = 1'b0;
        settle();
        // R3: zero input is not a NaN
        chk("R3", "zero nan", {63'd0, s_nan}, 64'd0);
        chk("R3", "zero sig", {63'd0, s_s}, 64'd0);

        for (int i = 0; i < NVEC; i++) begin
            @(posedge clk); #1;
            s_mode = VEC[i][67];
            s_val  = VEC[i][66:35];
            @(negedge clk);
            chk(s_mode ? "R2" : "R1", "quiet", {63'd0, s_q}, {63'd0, VEC[i][33]});
            chk(s_mode ? "R2" : "R1", "sig", {63'd0, s_s}, {63'd0, VEC[i][32]});
            chk("R3", "nan", {63'd0, s_nan}, {63'd0, VEC[i][34]});
            chk("R4", "invalid", {63'd0, s_inv}, {63'd0, VEC[i][32]});
            chk(s_mode ? "R6" : "R5", "quieted", {32'd0, s_qo}, {32'd0, VEC[i][31:0]});
        end

        // R7: default NaN in each mode
        @(posedge clk); #1; s_mode = 1'b0; @(negedge clk);
        chk("R7", "dflt mode0", {32'd0, s_df}, 64'h7FC00000);
        @(posedge clk); #1; s_mode = 1'b1; @(negedge clk);
        chk("R7", "dflt mode1", {32'd0, s_df}, 64'h7FBFFFFF);

        // R8: a clear-MSB NaN is quiet with signaling disabled
        @(posedge clk); #1; n_val = 32'h7F800001; n_mode = 1'b0; @(negedge clk);
        chk("R8", "quiet", {63'd0, n_q}, 64'd1);
        chk("R8", "sig", {63'd0, n_s}, 64'd0);
        chk("R8", "invalid", {63'd0, n_inv}, 64'd0);
        chk("R8", "quieted", {32'd0, n_qo}, 64'h7F800001);
        @(posedge clk); #1; n_val = 32'h7FC00000; n_mode = 1'b1; @(negedge clk);
        chk("R8", "mode1 sig", {63'd0, n_s}, 64'd0);

        // R9: half precision
        @(posedge clk); #1; h_val = 16'h7C01; h_mode = 1'b0; @(negedge clk);
        chk("R9", "half sig", {63'd0, h_s}, 64'd1);
        chk("R9", "half quieted", {48'd0, h_qo}, 64'h7E01);
        @(posedge clk); #1; h_val = 16'h7E00; h_mode = 1'b1; @(negedge clk);
        chk("R9", "half quieted mode1", {48'd0, h_qo}, 64'h7DFF);
        @(posedge clk); #1; h_val = 16'h7C00; @(negedge clk);
        chk("R9", "half inf", {63'd0, h_nan}, 64'd0);

        // R9: double precision
        @(posedge clk); #1; d_val = 64'h7FF0000000000001; d_mode = 1'b0; @(negedge clk);
        chk("R9", "double sig", {63'd0, d_s}, 64'd1);
        chk("R9", "double quieted", d_qo, 64'h7FF8000000000001);
        chk("R9", "double dflt", d_df, 64'h7FF8000000000000);
        @(posedge clk); #1; d_mode = 1'b1; @(negedge clk);
        chk("R9", "double quiet mode1", {63'd0, d_q}, 64'd1);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 5000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule